// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Edge Interrupts

This block controls one eight-pin general-purpose I/O port through a small 32-bit register bus. For each pin, software chooses one of four drive behaviours: input only, full push-pull drive, a driver that only pulls low, or a driver that only pulls high. The block turns that choice and an output data bit into pad-level enable and value signals. A separate per-pin bit switches the pad pull-up off.

Pad inputs pass through a two-flop synchronizer. The synchronized levels can be read back over the bus, and they also feed an edge detector. Each pin watches one edge direction at a time, set by its polarity bit. A detected edge sets a sticky event bit, which software clears by writing a one to it. A force register lets a test raise events without moving the pads. The single interrupt line is high whenever an enabled pin has a pending event.

Top module: `gpio_port8`

## Requirements
- R1: After reset, every register reads zero, `pad_oe` is 0x00, `pad_pu` is 0xFF and `irq` is low.
- R2: The following registers read back the low bits last written to them, and their unused upper bits read zero:
  - output data at 0x08 (8 bits)
  - drive mode at 0x0C (16 bits)
  - pull-up disable at 0x10 (8 bits)
  - interrupt enable at 0x18 (8 bits)
  - force at 0x1C (8 bits)
  - polarity at 0x20 (8 bits)
  
  Any unmapped address reads zero.
- R3: Address 0x04 returns the pad levels, one bit per pin. A pad change becomes visible after the second rising clock edge, and writes to this address have no effect.
- R4: The drive mode field for pin n sits at bits [2n+1:2n] of 0x0C. The codes behave as follows:
  - 00: never enables the driver
  - 01: always enables it
  - 10: enables it only while the output bit is 0
  - 11: enables it only while the output bit is 1
  
  `pad_out[n]` always equals output data bit n.
- R5: `pad_pu[n]` is the inverse of bit n of the pull-up disable register at 0x10.
- R6: Polarity bit n selects the edge for pin n: 0 detects a falling edge and 1 a rising edge. A detected edge sets event bit n at the third rising clock edge after the pad change. An edge in the other direction sets nothing.
- R7: Event bits at 0x14 stay set until a one is written to them. Writing a zero leaves a bit unchanged. An edge detected in the same cycle as a clear of that bit leaves the bit set.
- R8: `irq` is high exactly when some pin has both its event bit and its enable bit set. Pending events on disabled pins do not raise it.
- R9: While a force bit at 0x1C is set, the matching event bit is set on every cycle, even against a clear. Once force is written to zero, the event bit can be cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad driver enables |
| pad_pu | output | 8 | Pad pull-up enables |
| irq | output | 1 | Port interrupt |

## Verification
The hardest case to reach is an edge detection that lands on the same clock edge as a write-one clear of the same event bit. That timing depends on the exact depth of the synchronizer. The stimulus changes the pad on a falling clock edge, waits one more falling edge, and then issues the clear write. The write therefore commits on the third rising edge, the same edge on which the detector fires. The bench also reads the event register one cycle before and one cycle on the detection edge, which pins the latency down exactly.

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter int NPIN = 8,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_en,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_pu,
  output logic            irq
);
  localparam int MW = 2 * NPIN;
  localparam logic [AW-1:0] A_LVL = AW'(8'h04);
  localparam logic [AW-1:0] A_DAT = AW'(8'h08);
  localparam logic [AW-1:0] A_MOD = AW'(8'h0C);
  localparam logic [AW-1:0] A_PUD = AW'(8'h10);
  localparam logic [AW-1:0] A_EVT = AW'(8'h14);
  localparam logic [AW-1:0] A_IEN = AW'(8'h18);
  localparam logic [AW-1:0] A_FRC = AW'(8'h1C);
  localparam logic [AW-1:0] A_POL = AW'(8'h20);

  logic [NPIN-1:0] dout, pud, ien, frc, pol, evt;
  logic [MW-1:0]   mode;
  logic [NPIN-1:0] s1, s2, s3;
  logic [NPIN-1:0] det, clr;
  logic            wr;

  assign wr  = bus_en & bus_wr;
  assign det = (s2 & ~s3 & pol) | (~s2 & s3 & ~pol);
  assign clr = (wr && bus_addr == A_EVT) ? bus_wdata[NPIN-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0; pud <= '0; ien <= '0; frc <= '0; pol <= '0;
      evt  <= '0; mode <= '0; s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1  <= pad_in;
      s2  <= s1;
      s3  <= s2;
      evt <= (evt & ~clr) | det | frc;
      if (wr) begin
        case (bus_addr)
          A_DAT: dout <= bus_wdata[NPIN-1:0];
          A_MOD: mode <= bus_wdata[MW-1:0];
          A_PUD: pud  <= bus_wdata[NPIN-1:0];
          A_IEN: ien  <= bus_wdata[NPIN-1:0];
          A_FRC: frc  <= bus_wdata[NPIN-1:0];
          A_POL: pol  <= bus_wdata[NPIN-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_comb begin
      case (mode[2*i +: 2])
        2'b01:   pad_oe[i] = 1'b1;
        2'b10:   pad_oe[i] = ~dout[i];
        2'b11:   pad_oe[i] = dout[i];
        default: pad_oe[i] = 1'b0;
      endcase
    end
  end

  assign pad_out = dout;
  assign pad_pu  = ~pud;
  assign irq     = |(evt & ien);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LVL: bus_rdata[NPIN-1:0] = s2;
      A_DAT: bus_rdata[NPIN-1:0] = dout;
      A_MOD: bus_rdata[MW-1:0]   = mode;
      A_PUD: bus_rdata[NPIN-1:0] = pud;
      A_EVT: bus_rdata[NPIN-1:0] = evt;
      A_IEN: bus_rdata[NPIN-1:0] = ien;
      A_FRC: bus_rdata[NPIN-1:0] = frc;
      A_POL: bus_rdata[NPIN-1:0] = pol;
      default: ;
    endcase
  end

  // R7: without a clear write, pending events survive
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == A_EVT) |=> ((evt & $past(evt)) == $past(evt)));

  // R6: a qualifying synchronized edge lands in the event register
  a_r6_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (det != '0) |=> ((evt & $past(det)) == $past(det)));

  // R9: forced bits are pending on the next cycle regardless of clears
  a_r9_force: assert property (@(posedge clk) disable iff (!rst_n)
    (frc != '0) |=> ((evt & $past(frc)) == $past(frc)));

  // R8: interrupt only with some pending event
  a_r8_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt != '0));

  // R4: input mode pins never drive
  a_r4_input_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == '0) |-> (pad_oe == '0));
endmodule

// File: tb/sim_gpio_port8.sv
module sim_gpio_port8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out, pad_oe, pad_pu;
  logic        irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  gpio_port8 u0 (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .irq(irq));

  // {pin[2:0], mode[1:0], dout, expected oe}
  localparam logic [6:0] VEC [8] = '{
    7'b000_00_1_0, 7'b001_01_0_1, 7'b010_01_1_1, 7'b011_10_0_1,
    7'b100_10_1_0, 7'b101_11_1_1, 7'b110_11_0_0, 7'b111_00_0_0};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", {24'b0, pad_oe}, 32'h00);
    chk("R1 pu", {24'b0, pad_pu}, 32'hFF);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    for (int a = 4; a <= 32; a += 4) rdchk("R1 reg", 8'(a), 32'h0);

    // R4 drive-mode vectors
    foreach (VEC[i]) begin
      logic [2:0] p;
      p = VEC[i][6:4];
      wr(8'h0C, 32'(VEC[i][3:2]) << (2 * p));
      wr(8'h08, 32'(VEC[i][1]) << p);
      @(negedge clk);
      chk("R4 oe", {24'b0, pad_oe}, 32'(VEC[i][0]) << p);
      chk("R4 out", {24'b0, pad_out}, 32'(VEC[i][1]) << p);
      rdchk("R2 mode", 8'h0C, 32'(VEC[i][3:2]) << (2 * p));
    end
    wr(8'h0C, 32'h0); wr(8'h08, 32'h0);

    // R2 readback, upper bits zero, unmapped
    wr(8'h20, 32'hFFFF_FFA5); rdchk("R2 pol", 8'h20, 32'hA5);
    wr(8'h20, 32'h0);
    wr(8'h0C, 32'hFFFF_1234); rdchk("R2 mode16", 8'h0C, 32'h1234);
    wr(8'h0C, 32'h0);
    wr(8'h18, 32'h0000_0133); rdchk("R2 ien", 8'h18, 32'h33);
    wr(8'h18, 32'h0);
    rdchk("R2 unmapped", 8'h24, 32'h0);

    // R5 pull-up
    wr(8'h10, 32'h0F);
    chk("R5 pu", {24'b0, pad_pu}, 32'hF0);
    wr(8'h10, 32'h0);

    // R3 sync latency, R6 opposite edge ignored
    @(negedge clk); pad_in = 8'hA5;
    rdchk("R3 not yet", 8'h04, 32'h00);
    rdchk("R3 level", 8'h04, 32'hA5);
    wr(8'h04, 32'hFF);
    rdchk("R3 write ignored", 8'h04, 32'hA5);
    rdchk("R6 rising ignored", 8'h14, 32'h0);

    // R6 falling default
    @(negedge clk); pad_in = 8'h00;
    repeat (4) @(negedge clk);
    rdchk("R6 falling", 8'h14, 32'hA5);
    chk("R8 disabled", {31'b0, irq}, 32'h0);
    wr(8'h18, 32'h01);
    chk("R8 enabled", {31'b0, irq}, 32'h1);
    wr(8'h14, 32'h01);
    chk("R8 cleared", {31'b0, irq}, 32'h0);
    rdchk("R7 w1c", 8'h14, 32'hA4);
    wr(8'h14, 32'h00);
    rdchk("R7 zero write", 8'h14, 32'hA4);
    wr(8'h14, 32'hFF);
    rdchk("R7 clear all", 8'h14, 32'h0);

    // R6 rising with exact latency
    wr(8'h20, 32'h10);
    @(negedge clk); pad_in = 8'h30;
    @(negedge clk);
    rdchk("R6 latency", 8'h14, 32'h00);
    rdchk("R6 rising", 8'h14, 32'h10);
    wr(8'h14, 32'hFF);

    // R7 edge same cycle as clear
    @(negedge clk); pad_in = 8'h10;
    @(negedge clk);
    wr(8'h14, 32'h20);
    rdchk("R7 event beats clear", 8'h14, 32'h20);
    wr(8'h14, 32'hFF);

    // R9 force
    wr(8'h18, 32'h40);
    wr(8'h1C, 32'h42);
    rdchk("R9 forced", 8'h14, 32'h42);
    chk("R9 irq", {31'b0, irq}, 32'h1);
    wr(8'h14, 32'hFF);
    rdchk("R9 held", 8'h14, 32'h42);
    wr(8'h1C, 32'h0);
    wr(8'h14, 32'hFF);
    rdchk("R9 released", 8'h14, 32'h0);
    chk("R9 irq off", {31'b0, irq}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule